// File: doc/BRIEF.md
# I2C Slave Dual-Address Matcher

This block decides whether an I2C transfer is aimed at this device. A bit-level front end passes in a one-cycle pulse for each START or repeated START, and a byte strobe with the eight bits for every byte it shifts in. The matcher looks at the address portion that follows each START. In 7-bit mode that portion is one byte. In 10-bit mode it is a `11110` header byte carrying the two upper address bits and the R/W bit, followed by a byte carrying the lower eight address bits. For each address decision the block returns an ACK/NACK verdict to the front end.

Two programmable 10-bit addresses are compared in parallel. Each has its own 10-bit mask, and a mask bit set to 1 makes the matching received bit don't-care. When a general-call enable is set, the all-zero byte is also accepted. The block reports the captured R/W bit. It raises a selected flag, plus a read-request flag for reads, and keeps one sticky match flag per address. Each match flag is cleared by writing a 1 to its position on the clear input.

Top module: `slave_addr_matcher`

## Requirements
- R1: In 7-bit mode (`mode_10b`=0), received byte bits [7:1] are compared with address bits [6:0], and byte bit 0 is captured as the R/W bit. The cycle after a decision byte is strobed, `ack_valid` is high for exactly one cycle and `ack` gives the verdict (1 = ACK).
- R2: For each address, a mask bit of 1 makes the corresponding received address bit don't-care. A mask bit of 0 requires that bit to equal the programmed address bit.
- R3: An address programmed as 0x000 never matches, whatever its mask. In 7-bit mode, an address with any of bits [9:7] nonzero never matches.
- R4: In 10-bit mode, a first byte of the form `11110 A1 A0 x` has A1:A0 compared with address bits [9:8] under the mask, and x is captured as R/W. The header is ACKed when at least one address passes, but `selected` stays low.
- R5: In 10-bit mode, the byte after an ACKed header is compared with bits [7:0] of the addresses that passed the header, and is ACKed if any of them match. A header that no address passes is NACKed, and no verdict is given for the byte after it.
- R6: `match_flag[0]` and `match_flag[1]` are set when address 0 or address 1 completes a match. Both are set when both match. They hold until a 1 is written to the same bit of `flag_clr`, and a set in the same cycle as a clear wins. Both are 0 after reset.
- R7: With `gc_enable`=1, a first byte of 0x00 is ACKed and selects the device with R/W = 0, without setting any match flag. With `gc_enable`=0, a 0x00 byte is decided only by the address compare.
- R8: `selected` goes high together with the ACK verdict that completes a match. `read_req` goes high with it when the captured R/W bit is 1. Both are 0 after reset.
- R9: `bus_start` returns the matcher to waiting for a first byte and clears `selected` and `read_req`. A byte strobed in the same cycle as `bus_start` is ignored.
- R10: Once the address decision for a transfer has been made, further bytes produce no verdict and leave the outputs unchanged until the next `bus_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| byte_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte, MSB first as on the bus |
| mode_10b | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| gc_enable | input | 1 | Accept the general-call byte 0x00 |
| addr0 | input | 10 | Programmed address 0 |
| mask0 | input | 10 | Don't-care mask for address 0 |
| addr1 | input | 10 | Programmed address 1 |
| mask1 | input | 10 | Don't-care mask for address 1 |
| flag_clr | input | 2 | Write-one-to-clear strobe for the match flags |
| ack_valid | output | 1 | One-cycle pulse: `ack` holds a new verdict |
| ack | output | 1 | Verdict, 1 = ACK, 0 = NACK |
| rw_bit | output | 1 | R/W bit captured from the first address byte |
| selected | output | 1 | Device addressed in the current transfer |
| read_req | output | 1 | Device addressed for a read |
| match_flag | output | 2 | Sticky per-address match flags |

## Verification
The hardest case to reach is the 10-bit sequence where the header bits select only some of the addresses. The second byte must then be judged against those candidates only, even when it would match the other address's low byte. Purely random bytes almost never form a `11110` header that matches. The stimulus therefore builds headers and low bytes from the programmed addresses, flips bits only at chosen positions (some masked, some not), and aims directed transfers at an address pair that shares its low byte but differs in its upper bits.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int ADDR_W   = 10;
  localparam int NUM_ADDR = 2;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = ADDR_W - BYTE_W;
  localparam int SEVEN_W  = 7;
  localparam logic [4:0] HDR10_TAG = 5'b11110;

  typedef enum logic [1:0] {
    ST_FIRST = 2'd0,
    ST_LOW   = 2'd1,
    ST_HOLD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sam_cmp.sv
module sam_cmp
  import sam_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic [BYTE_W-1:0] rx,
  output logic              hit7,
  output logic              hit_hi,
  output logic              hit_lo
);
  logic                addr_live;
  logic                upper_clear;
  logic [SEVEN_W-1:0]  diff7;
  logic [HI_W-1:0]     diff_hi;
  logic [BYTE_W-1:0]   diff_lo;

  always_comb begin
    addr_live   = |addr;
    upper_clear = ~|addr[ADDR_W-1:SEVEN_W];
    diff7   = (rx[BYTE_W-1:1] ^ addr[SEVEN_W-1:0]) & ~mask[SEVEN_W-1:0];
    diff_hi = (rx[HI_W:1] ^ addr[ADDR_W-1:BYTE_W]) & ~mask[ADDR_W-1:BYTE_W];
    diff_lo = (rx ^ addr[BYTE_W-1:0]) & ~mask[BYTE_W-1:0];
    hit7    = addr_live && upper_clear && (diff7 == '0);
    hit_hi  = addr_live && (diff_hi == '0);
    hit_lo  = addr_live && (diff_lo == '0);
  end
endmodule

// File: rtl/sam_seq.sv
module sam_seq
  import sam_pkg::*;
#(
  parameter int N = NUM_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx,
  input  logic              mode_10b,
  input  logic              gc_enable,
  input  logic [N-1:0]      hit7,
  input  logic [N-1:0]      hit_hi,
  input  logic [N-1:0]      hit_lo,
  output logic              ack_valid,
  output logic              ack,
  output logic              rw_bit,
  output logic              selected,
  output logic              read_req,
  output logic [N-1:0]      hit_set
);
  seq_state_e state_q, state_d;
  logic [N-1:0] cand_q, cand_d;
  logic rw_q, rw_d;
  logic sel_q, sel_d;
  logic rd_q, rd_d;
  logic ack_q, ack_d;
  logic ackv_q, ackv_d;
  logic [N-1:0] hits;
  logic is_hdr, is_gc;
  logic step_en;

  assign step_en = bus_start | byte_valid;
  assign is_hdr  = mode_10b && (rx[BYTE_W-1:3] == HDR10_TAG);
  assign is_gc   = gc_enable && (rx == '0);

  always_comb begin
    state_d = state_q;
    cand_d  = cand_q;
    rw_d    = rw_q;
    sel_d   = sel_q;
    rd_d    = rd_q;
    ack_d   = ack_q;
    ackv_d  = 1'b0;
    hits    = '0;
    if (bus_start) begin
      state_d = ST_FIRST;
      cand_d  = '0;
      sel_d   = 1'b0;
      rd_d    = 1'b0;
    end else if (byte_valid) begin
      unique case (state_q)
        ST_FIRST: begin
          ackv_d = 1'b1;
          rw_d   = rx[0];
          if (is_hdr) begin
            cand_d  = hit_hi;
            ack_d   = |hit_hi;
            state_d = (|hit_hi) ? ST_LOW : ST_HOLD;
          end else begin
            hits    = mode_10b ? '0 : hit7;
            ack_d   = (|hits) || is_gc;
            sel_d   = (|hits) || is_gc;
            rd_d    = ((|hits) || is_gc) && rx[0];
            state_d = ST_HOLD;
          end
        end
        ST_LOW: begin
          hits    = cand_q & hit_lo;
          ackv_d  = 1'b1;
          ack_d   = |hits;
          sel_d   = |hits;
          rd_d    = (|hits) && rw_q;
          state_d = ST_HOLD;
        end
        default: begin
          state_d = ST_HOLD;
        end
      endcase
    end
  end

  assign hit_set = hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FIRST;
      cand_q  <= '0;
      rw_q    <= 1'b0;
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else if (step_en) begin
      state_q <= state_d;
      cand_q  <= cand_d;
      rw_q    <= rw_d;
      sel_q   <= sel_d;
      rd_q    <= rd_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ackv_q <= 1'b0;
    else        ackv_q <= ackv_d;
  end

  assign ack_valid = ackv_q;
  assign ack       = ack_q;
  assign rw_bit    = rw_q;
  assign selected  = sel_q;
  assign read_req  = rd_q;
endmodule

// File: rtl/sam_flags.sv
module sam_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_q, flag_d;
  logic         upd_en;

  assign upd_en = (|set) | (|clr);

  always_comb begin
    flag_d = (flag_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/slave_addr_matcher.sv
module slave_addr_matcher
  import sam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              mode_10b,
  input  logic              gc_enable,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [ADDR_W-1:0] mask0,
  input  logic [ADDR_W-1:0] addr1,
  input  logic [ADDR_W-1:0] mask1,
  input  logic [NUM_ADDR-1:0] flag_clr,
  output logic              ack_valid,
  output logic              ack,
  output logic              rw_bit,
  output logic              selected,
  output logic              read_req,
  output logic [NUM_ADDR-1:0] match_flag
);
  logic [NUM_ADDR-1:0][ADDR_W-1:0] addr_tab;
  logic [NUM_ADDR-1:0][ADDR_W-1:0] mask_tab;
  logic [NUM_ADDR-1:0] hit7, hit_hi, hit_lo, hit_set;

  assign addr_tab[0] = addr0;
  assign addr_tab[1] = addr1;
  assign mask_tab[0] = mask0;
  assign mask_tab[1] = mask1;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
    sam_cmp u_cmp (
      .addr   (addr_tab[i]),
      .mask   (mask_tab[i]),
      .rx     (rx_byte),
      .hit7   (hit7[i]),
      .hit_hi (hit_hi[i]),
      .hit_lo (hit_lo[i])
    );
  end

  sam_seq #(.N(NUM_ADDR)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_start  (bus_start),
    .byte_valid (byte_valid),
    .rx         (rx_byte),
    .mode_10b   (mode_10b),
    .gc_enable  (gc_enable),
    .hit7       (hit7),
    .hit_hi     (hit_hi),
    .hit_lo     (hit_lo),
    .ack_valid  (ack_valid),
    .ack        (ack),
    .rw_bit     (rw_bit),
    .selected   (selected),
    .read_req   (read_req),
    .hit_set    (hit_set)
  );

  sam_flags #(.N(NUM_ADDR)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit_set),
    .clr   (flag_clr),
    .flag  (match_flag)
  );
endmodule

// File: rtl/sam_checker.sv
module sam_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_start,
  input logic       byte_valid,
  input logic [1:0] flag_clr,
  input logic       ack_valid,
  input logic       ack,
  input logic       selected,
  input logic       read_req,
  input logic [1:0] match_flag
);
  assert_verdict_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(byte_valid));

  assert_select_needs_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(byte_valid));

  assert_select_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> (ack_valid && ack));

  assert_read_implies_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_req |-> selected);

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (!selected && !read_req && !ack_valid));

  assert_flag0_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_flag[0]) |-> $past(flag_clr[0]));

  assert_flag1_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_flag[1]) |-> $past(flag_clr[1]));
endmodule

bind slave_addr_matcher sam_checker u_sam_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_start  (bus_start),
  .byte_valid (byte_valid),
  .flag_clr   (flag_clr),
  .ack_valid  (ack_valid),
  .ack        (ack),
  .selected   (selected),
  .read_req   (read_req),
  .match_flag (match_flag)
);

// File: tb/slave_addr_matcher_test.sv
module slave_addr_matcher_test;
  logic clk, rst_n, bus_start, byte_valid, mode_10b, gc_enable;
  logic [7:0] rx_byte;
  logic [9:0] addr0, mask0, addr1, mask1;
  logic [1:0] flag_clr;
  logic ack_valid, ack, rw_bit, selected, read_req;
  logic [1:0] match_flag;

  int n_chk = 0;
  int n_bad = 0;

  int         m_st;
  logic [1:0] m_cand, m_flag;
  logic       m_rw, m_sel, m_rd;

  slave_addr_matcher uut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .byte_valid(byte_valid),
    .rx_byte(rx_byte), .mode_10b(mode_10b), .gc_enable(gc_enable),
    .addr0(addr0), .mask0(mask0), .addr1(addr1), .mask1(mask1),
    .flag_clr(flag_clr), .ack_valid(ack_valid), .ack(ack), .rw_bit(rw_bit),
    .selected(selected), .read_req(read_req), .match_flag(match_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic f_hit7(input logic [9:0] a, input logic [9:0] m, input logic [7:0] b);
    return (a != 0) && (a[9:7] == 0) && (((b[7:1] ^ a[6:0]) & ~m[6:0]) == 0);
  endfunction

  function automatic logic f_hi(input logic [9:0] a, input logic [9:0] m, input logic [7:0] b);
    return (a != 0) && (((b[2:1] ^ a[9:8]) & ~m[9:8]) == 0);
  endfunction

  function automatic logic f_lo(input logic [9:0] a, input logic [9:0] m, input logic [7:0] b);
    return (a != 0) && (((b ^ a[7:0]) & ~m[7:0]) == 0);
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " selected"}, selected, m_sel);
    chk({tag, " read_req"}, read_req, m_rd);
    chk({tag, " match_flag"}, match_flag, m_flag);
  endtask

  task automatic do_byte(input logic [7:0] b, input logic [1:0] clr, input string tag);
    logic ev, ea;
    logic [1:0] st, c;
    ev = 1'b0; ea = 1'b0; st = 2'b00;
    if (m_st == 0) begin
      ev = 1'b1;
      m_rw = b[0];
      if (mode_10b && b[7:3] == 5'b11110) begin
        c = {f_hi(addr1, mask1, b), f_hi(addr0, mask0, b)};
        ea = |c;
        m_cand = c;
        m_st = ea ? 1 : 2;
      end else begin
        st = mode_10b ? 2'b00 : {f_hit7(addr1, mask1, b), f_hit7(addr0, mask0, b)};
        ea = (|st) || (gc_enable && b == 8'h00);
        m_sel = ea;
        m_rd = ea && b[0];
        m_st = 2;
      end
    end else if (m_st == 1) begin
      ev = 1'b1;
      st = m_cand & {f_lo(addr1, mask1, b), f_lo(addr0, mask0, b)};
      ea = |st;
      m_sel = ea;
      m_rd = ea && m_rw;
      m_st = 2;
    end
    m_flag = (m_flag & ~clr) | st;
    @(negedge clk);
    byte_valid = 1'b1; rx_byte = b; flag_clr = clr;
    @(negedge clk);
    byte_valid = 1'b0; flag_clr = 2'b00;
    chk({tag, " ack_valid"}, ack_valid, ev);
    if (ev) begin
      chk({tag, " ack"}, ack, ea);
      chk({tag, " rw_bit"}, rw_bit, m_rw);
    end
    check_state(tag);
  endtask

  task automatic do_start(input bit with_byte, input logic [7:0] b);
    m_st = 0; m_cand = 2'b00; m_sel = 1'b0; m_rd = 1'b0;
    @(negedge clk);
    bus_start = 1'b1;
    if (with_byte) begin byte_valid = 1'b1; rx_byte = b; end
    @(negedge clk);
    bus_start = 1'b0; byte_valid = 1'b0;
    chk("R9 ack_valid after start", ack_valid, 1'b0);
    check_state("R9 start");
  endtask

  task automatic do_clr(input logic [1:0] c);
    m_flag = m_flag & ~c;
    @(negedge clk); flag_clr = c;
    @(negedge clk); flag_clr = 2'b00;
    chk("R6 flag after clear", match_flag, m_flag);
  endtask

  function automatic logic [9:0] sparse10();
    logic [31:0] a, b;
    a = $urandom; b = $urandom;
    return a[9:0] & b[9:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_start = 1'b0; byte_valid = 1'b0; rx_byte = 8'h00;
    mode_10b = 1'b0; gc_enable = 1'b0; flag_clr = 2'b00;
    addr0 = '0; mask0 = '0; addr1 = '0; mask1 = '0;
    m_st = 0; m_cand = 0; m_flag = 0; m_rw = 0; m_sel = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset selected", selected, 1'b0);
    chk("R8 reset read_req", read_req, 1'b0);
    chk("R6 reset flags", match_flag, 2'b00);
    chk("R1 reset ack_valid", ack_valid, 1'b0);

    // R1 / R8: plain 7-bit read
    addr0 = 10'h03A; mask0 = 10'h000; addr1 = 10'h011; mask1 = 10'h000;
    do_start(0, 8'h00);
    do_byte({7'h3A, 1'b1}, 2'b00, "R1 7bit read");
    chk("R8 read_req literal", read_req, 1'b1);
    chk("R6 flag0 literal", match_flag, 2'b01);
    // R10: later bytes give no verdict
    do_byte({7'h11, 1'b0}, 2'b00, "R10 extra byte");
    do_byte(8'h74, 2'b00, "R10 extra byte 2");
    // R2: masked bits
    mask0 = 10'h003;
    do_start(0, 8'h00);
    do_byte({7'h39, 1'b0}, 2'b00, "R2 masked match");
    do_start(0, 8'h00);
    do_byte({7'h3E, 1'b0}, 2'b00, "R2 unmasked miss");
    chk("R2 nack literal", ack, 1'b0);
    // R3: zero address and upper bits in 7-bit mode
    addr0 = 10'h000; mask0 = 10'h3FF;
    do_start(0, 8'h00);
    do_byte(8'h5C, 2'b00, "R3 zero addr");
    addr0 = 10'h0BA; mask0 = 10'h000;
    do_start(0, 8'h00);
    do_byte({7'h3A, 1'b0}, 2'b00, "R3 upper bits set");
    chk("R3 nack literal", ack, 1'b0);
    // R6: both match, clear, set wins
    do_clr(2'b11);
    addr0 = 10'h050; mask0 = 10'h000; addr1 = 10'h051; mask1 = 10'h001;
    do_start(0, 8'h00);
    do_byte({7'h50, 1'b0}, 2'b00, "R6 both match");
    chk("R6 both literal", match_flag, 2'b11);
    do_clr(2'b01);
    do_start(0, 8'h00);
    do_byte({7'h50, 1'b0}, 2'b11, "R6 set beats clear");
    // R7: general call
    do_clr(2'b11);
    gc_enable = 1'b1;
    do_start(0, 8'h00);
    do_byte(8'h00, 2'b00, "R7 gc on");
    chk("R7 gc selected literal", selected, 1'b1);
    gc_enable = 1'b0;
    do_start(0, 8'h00);
    do_byte(8'h00, 2'b00, "R7 gc off");
    // R4 / R5: 10-bit
    mode_10b = 1'b1;
    addr0 = 10'h2C5; mask0 = 10'h000; addr1 = 10'h1C5; mask1 = 10'h000;
    do_start(0, 8'h00);
    do_byte({5'b11110, 2'b10, 1'b1}, 2'b00, "R4 header");
    chk("R4 not yet selected", selected, 1'b0);
    do_byte(8'hC5, 2'b00, "R5 low byte");
    chk("R5 only addr0 flagged", match_flag, 2'b01);
    do_start(0, 8'h00);
    do_byte({5'b11110, 2'b00, 1'b0}, 2'b00, "R5 header miss");
    do_byte(8'hC5, 2'b00, "R5 ignored after miss");
    do_start(0, 8'h00);
    do_byte({5'b11110, 2'b01, 1'b0}, 2'b00, "R4 header addr1");
    do_byte(8'hC4, 2'b00, "R5 low miss");
    // R9: restart mid-sequence, and start with a byte in the same cycle
    do_start(0, 8'h00);
    do_byte({5'b11110, 2'b10, 1'b0}, 2'b00, "R4 header again");
    do_start(1, 8'hC5);
    do_byte({5'b11110, 2'b01, 1'b1}, 2'b00, "R9 first after restart");
    do_byte(8'hC5, 2'b00, "R9 low after restart");

    // random phase
    for (int t = 0; t < 400; t++) begin
      r = $urandom;
      mode_10b = r[0];
      gc_enable = r[1];
      addr0 = r[2] ? sparse10() : 10'($urandom);
      addr1 = r[3] ? 10'h000 : 10'($urandom);
      if (!mode_10b && r[4]) begin addr0[9:7] = 3'b000; addr1[9:7] = 3'b000; end
      if (r[13]) addr1[7:0] = addr0[7:0];
      mask0 = r[5] ? sparse10() : 10'h000;
      mask1 = r[6] ? sparse10() : 10'h000;
      do_start(0, 8'h00);
      begin
        logic [9:0] tgt;
        logic [31:0] f;
        tgt = r[7] ? addr1 : addr0;
        f = $urandom;
        if (mode_10b) begin
          do_byte({5'b11110, tgt[9:8] ^ (r[8] ? f[1:0] : 2'b00), f[2]},
                  r[11:10], "R4 random header");
          do_byte(tgt[7:0] ^ (r[9] ? (f[10:3] & f[18:11]) : 8'h00),
                  2'b00, "R5 random low");
        end else if (r[12]) begin
          do_byte(8'($urandom), r[11:10], "R1 random byte");
        end else begin
          do_byte({tgt[6:0] ^ (r[8] ? (f[6:0] & f[13:7]) : 7'h00), f[14]},
                  r[11:10], "R2 random byte");
        end
        do_byte(8'($urandom), 2'b00, "R10 random trailing");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule